// File: doc/BRIEF.md
# Asynchronous Byte Deframer with Clocked Serial Readout

The block takes an oversampled serial line that already carries plain logic levels and recovers asynchronous characters from it. Each character is a low start bit, eight data bits with the least significant first, and a high stop bit. The block finds the falling edge of the start bit and confirms it at the middle of the start bit. It then samples every data bit and the stop bit at their mid-points.

When a good character ends, the byte is copied into a holding register and an active-low ready flag drops. An external controller then clocks the byte out one bit per rising edge of its own read clock. That read clock is asynchronous to the system clock. The ready flag returns high on the first read edge, or by itself after half a bit period if no read edge comes.

A registered active-low interrupt output merges the ready flag with two status inputs: an active-low ring indication and an active-high carrier indication. A sleep input masks the carrier indication.

Top module: `serial_byte_deframer`

## Requirements
- R1: Each character is a 0 start bit, data bits b0..b7 in that order on the line, and a 1 stop bit. The byte read out equals the byte sent.
- R2: After a character whose stop bit samples as 1, `ready_n` goes low. `ready_n` never falls without a completed character.
- R3: If no read edge arrives, `ready_n` stays low for exactly CLKS_PER_SAMPLE*OVERSAMPLE/2 system clocks (32 by default) and then returns high.
- R4: The first rising edge on `rd_clk` returns `ready_n` high within 3 system clocks of that edge.
- R5: `rd_data` shows b0 once a byte is held. Each rising edge of `rd_clk` advances it to the next bit. After the eighth edge it shows 1, and further edges change nothing until the next byte.
- R6: A start bit that reads 1 at its mid-point is discarded, and no `ready_n` pulse follows.
- R7: A stop bit that samples as 0 is a framing error and gives no `ready_n` pulse. The receiver then looks for no new start bit until the line has been seen high.
- R8: A new character can be received while the previous byte is read out. `rd_data` keeps serving the held byte until the new stop bit is accepted.
- R9: `irq_n` is low one clock after `ring_n` is low, after `ready_n` is low, or after `carrier` is high while `sleep` is low.
- R10: While `sleep` is 1, `carrier` has no effect on `irq_n`. With `ring_n` high and `ready_n` high, `irq_n` is 1.
- R11: After reset, `ready_n`, `irq_n` and `rd_data` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Demodulated serial line, idle high |
| rd_clk | input | 1 | Asynchronous read clock from the controller |
| ring_n | input | 1 | Ring indication, active low |
| carrier | input | 1 | Carrier indication, active high |
| sleep | input | 1 | Masks `carrier` when high |
| rd_data | output | 1 | Serial data out, one held bit per read edge |
| ready_n | output | 1 | Byte-ready flag, active low |
| irq_n | output | 1 | Merged interrupt, active low |

## Verification
A read edge on `rd_clk` crosses two synchroniser flops and an edge register, so `rd_data` and `ready_n` respond on the third system clock after the edge. The bench therefore holds each read level for four clocks before it samples. `ready_n` falls one clock after the mid-stop sample, and `irq_n` follows one clock later. Rather than predict the exact fall cycle, which depends on the oversampling phase, the bench counts low cycles of `ready_n` and `irq_n` at falling clock edges over each character and compares them with the half-bit length. Status-input changes on `irq_n` are sampled two clocks after the change.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_t;
endpackage

// File: rtl/deframer_tick.sv
module deframer_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/deframer_rx.sv
module deframer_rx
  import deframer_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx_line,
  output logic                 byte_done,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int unsigned SW = $clog2(OVERSAMPLE);
  localparam int unsigned BW = $clog2(DATA_BITS);
  localparam logic [SW-1:0] HALF_LAST = SW'(OVERSAMPLE/2 - 1);
  localparam logic [SW-1:0] FULL_LAST = SW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

  logic                 sync1, sync2;
  rx_state_t            state;
  logic [SW-1:0]        scnt;
  logic [BW-1:0]        bcnt;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rx_line;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      scnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_out  <= '0;
    end else begin
      byte_done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && !sync2) begin
            state <= RX_START;
            scnt  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (scnt == HALF_LAST) begin
              scnt  <= '0;
              bcnt  <= '0;
              state <= sync2 ? RX_IDLE : RX_DATA;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (scnt == FULL_LAST) begin
              scnt  <= '0;
              shreg <= {sync2, shreg[DATA_BITS-1:1]};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == BIT_LAST) state <= RX_STOP;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (scnt == FULL_LAST) begin
              scnt <= '0;
              if (sync2) begin
                byte_done <= 1'b1;
                byte_out  <= shreg;
                state     <= RX_IDLE;
              end else begin
                state <= RX_WAIT_HIGH;
              end
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        RX_WAIT_HIGH: begin
          if (sync2) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/deframer_readout.sv
module deframer_readout #(
  parameter int unsigned DATA_BITS     = 8,
  parameter int unsigned HALF_BIT_CLKS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 byte_done,
  input  logic [DATA_BITS-1:0] byte_in,
  input  logic                 rd_clk,
  output logic                 rd_edge,
  output logic                 rd_data,
  output logic                 ready_n
);
  localparam int unsigned IW = $clog2(DATA_BITS + 1);
  localparam int unsigned TW = $clog2(HALF_BIT_CLKS + 1);
  localparam logic [IW-1:0] IDX_END  = IW'(DATA_BITS);
  localparam logic [TW-1:0] TMR_LAST = TW'(HALF_BIT_CLKS - 1);

  logic                 rs1, rs2, rs3;
  logic [DATA_BITS-1:0] hold;
  logic [IW-1:0]        idx;
  logic [TW-1:0]        tmr;
  logic [IW-1:0]        idx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
      rs3 <= 1'b0;
    end else begin
      rs1 <= rd_clk;
      rs2 <= rs1;
      rs3 <= rs2;
    end
  end

  assign rd_edge  = rs2 & ~rs3;
  assign idx_next = idx + 1'b1;

  function automatic logic pick(input logic [DATA_BITS-1:0] v, input logic [IW-1:0] i);
    logic r;
    r = 1'b1;
    for (int k = 0; k < DATA_BITS; k++)
      if (i == IW'(k)) r = v[k];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      idx     <= IDX_END;
      tmr     <= '0;
      rd_data <= 1'b1;
      ready_n <= 1'b1;
    end else if (byte_done) begin
      hold    <= byte_in;
      idx     <= '0;
      tmr     <= '0;
      rd_data <= byte_in[0];
      ready_n <= 1'b0;
    end else begin
      if (rd_edge) begin
        ready_n <= 1'b1;
        if (idx != IDX_END) begin
          idx     <= idx_next;
          rd_data <= pick(hold, idx_next);
        end
      end else if (!ready_n) begin
        if (tmr == TMR_LAST) ready_n <= 1'b1;
        else                 tmr     <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/deframer_irq.sv
module deframer_irq (
  input  logic clk,
  input  logic rst,
  input  logic ring_n,
  input  logic ready_n,
  input  logic carrier,
  input  logic sleep,
  output logic irq_n
);
  logic carrier_live;

  assign carrier_live = carrier & ~sleep;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(~ring_n | ~ready_n | carrier_live);
  end
endmodule

// File: rtl/serial_byte_deframer.sv
module serial_byte_deframer #(
  parameter int unsigned CLKS_PER_SAMPLE = 4,
  parameter int unsigned OVERSAMPLE      = 16,
  parameter int unsigned DATA_BITS       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic rd_clk,
  input  logic ring_n,
  input  logic carrier,
  input  logic sleep,
  output logic rd_data,
  output logic ready_n,
  output logic irq_n
);
  localparam int unsigned HALF_BIT_CLKS = CLKS_PER_SAMPLE * OVERSAMPLE / 2;

  logic                 tick;
  logic                 byte_done;
  logic [DATA_BITS-1:0] byte_val;
  logic                 rd_edge;

  deframer_tick #(.DIV(CLKS_PER_SAMPLE)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  deframer_rx #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rx_line   (rx_line),
    .byte_done (byte_done),
    .byte_out  (byte_val)
  );

  deframer_readout #(.DATA_BITS(DATA_BITS), .HALF_BIT_CLKS(HALF_BIT_CLKS)) u_rdout (
    .clk       (clk),
    .rst       (rst),
    .byte_done (byte_done),
    .byte_in   (byte_val),
    .rd_clk    (rd_clk),
    .rd_edge   (rd_edge),
    .rd_data   (rd_data),
    .ready_n   (ready_n)
  );

  deframer_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .ring_n  (ring_n),
    .ready_n (ready_n),
    .carrier (carrier),
    .sleep   (sleep),
    .irq_n   (irq_n)
  );
endmodule

// File: rtl/serial_byte_deframer_chk.sv
module serial_byte_deframer_chk #(
  parameter int unsigned CLKS_PER_SAMPLE = 4,
  parameter int unsigned OVERSAMPLE      = 16
) (
  input logic clk,
  input logic rst,
  input logic ring_n,
  input logic carrier,
  input logic sleep,
  input logic ready_n,
  input logic irq_n,
  input logic rd_edge,
  input logic byte_done
);
  localparam int unsigned HALF = CLKS_PER_SAMPLE * OVERSAMPLE / 2;

  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst)           low_run <= 0;
    else if (!ready_n) low_run <= low_run + 1;
    else               low_run <= 0;
  end

  assert_ready_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    low_run <= HALF);

  assert_ready_needs_byte_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_n) |-> $past(byte_done));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_edge && !byte_done) |=> ready_n);

  assert_ring_irq_R9: assert property (@(posedge clk) disable iff (rst)
    !ring_n |=> !irq_n);

  assert_carrier_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (carrier && !sleep) |=> !irq_n);

  assert_sleep_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (ring_n && ready_n && (sleep || !carrier)) |=> irq_n);
endmodule

bind serial_byte_deframer serial_byte_deframer_chk #(
  .CLKS_PER_SAMPLE(CLKS_PER_SAMPLE),
  .OVERSAMPLE(OVERSAMPLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ring_n    (ring_n),
  .carrier   (carrier),
  .sleep     (sleep),
  .ready_n   (ready_n),
  .irq_n     (irq_n),
  .rd_edge   (rd_edge),
  .byte_done (byte_done)
);

// File: tb/serial_byte_deframer_tb.sv
module serial_byte_deframer_tb;
  localparam int CPS      = 4;
  localparam int OS       = 16;
  localparam int BIT_CLKS = CPS * OS;
  localparam int HALF     = BIT_CLKS / 2;

  // each entry: {byte, stop bit}; a 0 stop bit means no ready pulse is due
  localparam logic [8:0] VEC [6] = '{
    {8'h00, 1'b1}, {8'hFF, 1'b1}, {8'hA5, 1'b1},
    {8'h3C, 1'b0}, {8'h81, 1'b1}, {8'h6E, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic rd_clk = 1'b0;
  logic ring_n = 1'b1;
  logic carrier = 1'b0;
  logic sleep = 1'b0;
  logic rd_data, ready_n, irq_n;

  int errors = 0;
  int checks = 0;
  int rdy_low_total = 0;
  int irq_low_total = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_byte_deframer #(.CLKS_PER_SAMPLE(CPS), .OVERSAMPLE(OS)) u_dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rd_clk(rd_clk),
    .ring_n(ring_n), .carrier(carrier), .sleep(sleep),
    .rd_data(rd_data), .ready_n(ready_n), .irq_n(irq_n)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (!ready_n) rdy_low_total <= rdy_low_total + 1;
      if (!irq_n)   irq_low_total <= irq_low_total + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rx_line = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_line = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    for (int i = 0; i < 8; i++) begin
      check(req, rd_data, exp[i]);
      rd_clk = 1'b1;
      repeat (4) @(negedge clk);
      rd_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    check("R5 after eighth edge", rd_data, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r0, i0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ready_n", ready_n, 1);
    check("R11 irq_n", irq_n, 1);
    check("R11 rd_data", rd_data, 1);

    // table walk: R1, R2, R3, R5, R7, R9
    for (int v = 0; v < 6; v++) begin
      r0 = rdy_low_total;
      i0 = irq_low_total;
      send_frame(VEC[v][8:1], VEC[v][0]);
      if (VEC[v][0]) begin
        check("R3 ready low length", rdy_low_total - r0, HALF);
        check("R9 irq follows ready", irq_low_total - i0, HALF);
        read_byte(VEC[v][8:1], "R1 readout bit");
      end else begin
        check("R7 framing no ready", rdy_low_total - r0, 0);
      end
    end

    // R5 extra edges ignored
    rd_clk = 1'b1; repeat (4) @(negedge clk);
    rd_clk = 1'b0; repeat (4) @(negedge clk);
    check("R5 ninth edge ignored", rd_data, 1);
    check("R5 ninth edge ready", ready_n, 1);

    // R6 start glitch
    r0 = rdy_low_total;
    rx_line = 1'b0;
    repeat (2 * CPS) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R6 glitch no ready", rdy_low_total - r0, 0);
    send_frame(8'h5A, 1'b1);
    read_byte(8'h5A, "R6 recovery bit");

    // R7 line held low after bad stop
    r0 = rdy_low_total;
    rx_line = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
    end
    repeat (3 * BIT_CLKS) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check("R7 waits for high", rdy_low_total - r0, 0);

    // R4 read edge clears ready early
    fork
      send_frame(8'hC7, 1'b1);
      begin
        @(negedge clk iff !ready_n);
        rd_clk = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 ready cleared", ready_n, 1);
        check("R5 advanced to b1", rd_data, 1);
        rd_clk = 1'b0;
      end
    join

    // R8 readout overlaps next reception
    send_frame(8'h39, 1'b1);
    fork
      send_frame(8'hE2, 1'b1);
      read_byte(8'h39, "R8 held byte bit");
    join
    check("R8 new byte b0", rd_data, 0);

    // R9 / R10 status inputs
    ring_n = 1'b0; repeat (2) @(negedge clk);
    check("R9 ring", irq_n, 0);
    ring_n = 1'b1; repeat (2) @(negedge clk);
    check("R9 ring release", irq_n, 1);
    carrier = 1'b1; repeat (2) @(negedge clk);
    check("R9 carrier", irq_n, 0);
    sleep = 1'b1; repeat (2) @(negedge clk);
    check("R10 sleep masks carrier", irq_n, 1);
    carrier = 1'b0; sleep = 1'b0; repeat (2) @(negedge clk);
    check("R10 idle", irq_n, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule